// File: doc/BRIEF.md
# Boot ROM Access Sequencer

This block stands between a host request port and an external boot ROM or flash part. When a request is accepted it decodes the 32-bit address against two fixed 8 MB windows at the top of the address space and asserts the chip select for the matching bank. It forms the word address the device needs for the configured data-bus width. It then times the access with two programmable wait-state counts: one for a single access or the first beat of a burst, and one for the later beats of a burst.

The length of a beat depends on the kind of access: wide read, byte-wide read, write, registered interface, or a follow-on burst beat. Each is a fixed offset from the programmed count. The latency fields and all mode inputs are captured when a request is accepted, so boot code may reprogram them at any time. An address outside both windows is answered with a one-cycle error pulse, and no device cycle starts.

Control is a three-state machine. `S_IDLE` waits for a request. `S_FIRST` times a single access or the first beat of a burst. `S_BURST` times burst beats two to four. The transitions are:
- T_ACCEPT: `S_IDLE`→`S_FIRST`
- T_DONE1: `S_FIRST`→`S_IDLE` (no burst)
- T_TOBURST: `S_FIRST`→`S_BURST`
- T_NEXT: `S_BURST`→`S_BURST`
- T_DONEB: `S_BURST`→`S_IDLE` after the fourth beat

Top module: `rom_access_seq`

## Requirements
- R1: `bank_sel_o[0]` is asserted for accepted addresses 0xFF80_0000 to 0xFFFF_FFFF, and `bank_sel_o[1]` for 0xFF00_0000 to 0xFF7F_FFFF. The asserted select holds steady in every cycle in which `busy_o` is high. At most one select is ever high, and none is high while `busy_o` is low.
- R2: A request accepted in idle whose address lies in neither window raises `err_o` for exactly the first cycle after the accepting edge. It asserts no select and leaves `busy_o` low.
- R3: The `width_i` encoding is 2'b00 for a 64-bit device, 2'b01 for a 32-bit device, and 2'b1x for an 8-bit device. `rom_addr_o` (21 bits) carries the following:
  - 64-bit: address bits [22:3] on bits [19:0], with bit 20 at zero.
  - 32-bit: address bits [22:2].
  - 8-bit: address bits [20:0].
- R4: The access time N of a beat is counted in clock periods after the edge that starts it. `beat_valid_o` is high only in the Nth period. A 64- or 32-bit read takes first-latency+3 periods, plus one more when `regd_i` is set.
- R5: An 8-bit read takes first-latency+2 periods, plus one more when `regd_i` is set.
- R6: A write takes first-latency+2 periods for any width and regardless of `regd_i`. `we_o` is high and `oe_o` low for the whole access. A write is always a single beat, even when `burst_i` is set.
- R7: A read with `burst_i` set delivers four beats. The two low bits of `rom_addr_o` advance by one per beat, modulo 4, from the starting value. The upper bits and the select are unchanged.
- R8: With `burst_en_i` set, beats two to four each take burst-latency+2 periods after the previous beat's valid period. With `burst_en_i` clear, each of them takes the first-beat read time from R4/R5.
- R9: The latency fields and mode inputs are captured at acceptance. Changing them while `busy_o` is high does not change the access in progress.
- R10: `busy_o` rises in the first period after acceptance and falls right after the final beat's valid period. A request presented while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled when idle |
| addr_i | input | 32 | Request byte address |
| wr_i | input | 1 | 1 = write, 0 = read |
| burst_i | input | 1 | Request a four-beat burst read |
| width_i | input | 2 | Device width code (R3) |
| regd_i | input | 1 | Registered interface adds one read cycle |
| burst_en_i | input | 1 | Enable fast burst-beat timing |
| first_lat_i | input | 5 | First-access wait states |
| beat_lat_i | input | 4 | Burst-beat wait states |
| bank_sel_o | output | 2 | Bank chip selects, active high |
| rom_addr_o | output | 21 | Device word address |
| oe_o | output | 1 | Output enable during reads |
| we_o | output | 1 | Write enable during writes |
| beat_valid_o | output | 1 | Beat complete strobe |
| busy_o | output | 1 | Access in progress |
| err_o | output | 1 | Out-of-window request pulse |

## Verification
Each request is driven on a falling edge and accepted on the next rising edge. After that the bench counts falling edges. A beat of access time N must show `beat_valid_o` at exactly count N after its start, never earlier. The error pulse is due at count 1. `busy_o` must stay high up to the last valid strobe and be low at the next count. Selects, address and enables are sampled on falling edges only, once per period, so each comparison sees registered state that settled half a cycle earlier.

// File: rtl/rom_seq_pkg.sv
package rom_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FIRST = 2'd1,
        S_BURST = 2'd2
    } seq_state_e;

    localparam logic [1:0] WIDTH_64 = 2'b00;
    localparam logic [1:0] WIDTH_32 = 2'b01;

endpackage

// File: rtl/rom_bank_decode.sv
module rom_bank_decode
    import rom_seq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BANK_BITS = 23,
    parameter int NBANKS    = 2,
    parameter int RA_W      = BANK_BITS - 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        width_i,
    output logic              hit_o,
    output logic [NBANKS-1:0] sel_o,
    output logic [RA_W-1:0]   rom_addr_o
);
    localparam int TAG_W = ADDR_W - BANK_BITS;
    localparam logic [TAG_W-1:0] TOP_TAG = {TAG_W{1'b1}};

    logic [TAG_W-1:0] tag;
    assign tag = addr_i[ADDR_W-1:BANK_BITS];

    // Bank k owns the k-th window counting down from the top of memory.
    for (genvar k = 0; k < NBANKS; k++) begin : g_bank
        assign sel_o[k] = (tag == TOP_TAG - TAG_W'(k));
    end

    assign hit_o = |sel_o;

    always_comb begin
        if (width_i[1]) begin
            rom_addr_o = addr_i[RA_W-1:0];
        end else if (width_i == WIDTH_32) begin
            rom_addr_o = addr_i[BANK_BITS-1:2];
        end else begin
            rom_addr_o = {1'b0, addr_i[BANK_BITS-1:3]};
        end
    end
endmodule

// File: rtl/rom_latency_calc.sv
module rom_latency_calc #(
    parameter int FLAT_W = 5,
    parameter int BLAT_W = 4,
    parameter int CNT_W  = FLAT_W + 1
) (
    input  logic              wr_i,
    input  logic              narrow_i,
    input  logic              regd_i,
    input  logic              burst_en_i,
    input  logic [FLAT_W-1:0] flat_i,
    input  logic [BLAT_W-1:0] blat_i,
    output logic [CNT_W-1:0]  first_len_o,
    output logic [CNT_W-1:0]  beat_len_o
);
    logic [CNT_W-1:0] read_len;

    always_comb begin
        read_len = CNT_W'(flat_i) + (narrow_i ? CNT_W'(2) : CNT_W'(3))
                 + CNT_W'(regd_i);
        if (wr_i) begin
            first_len_o = CNT_W'(flat_i) + CNT_W'(2);
        end else begin
            first_len_o = read_len;
        end
        if (burst_en_i) begin
            beat_len_o = CNT_W'(blat_i) + CNT_W'(2);
        end else begin
            beat_len_o = read_len;
        end
    end
endmodule

// File: rtl/rom_wait_counter.sv
module rom_wait_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R4: a running count steps down by exactly one per cycle
    p_countdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rom_access_seq.sv
module rom_access_seq
    import rom_seq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BANK_BITS = 23,
    parameter int NBANKS    = 2,
    parameter int FLAT_W    = 5,
    parameter int BLAT_W    = 4,
    parameter int BEATS     = 4,
    parameter int RA_W      = BANK_BITS - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [31:0]       addr_i,
    input  logic              wr_i,
    input  logic              burst_i,
    input  logic [1:0]        width_i,
    input  logic              regd_i,
    input  logic              burst_en_i,
    input  logic [4:0]        first_lat_i,
    input  logic [3:0]        beat_lat_i,
    output logic [1:0]        bank_sel_o,
    output logic [20:0]       rom_addr_o,
    output logic              oe_o,
    output logic              we_o,
    output logic              beat_valid_o,
    output logic              busy_o,
    output logic              err_o
);
    localparam int CNT_W = FLAT_W + 1;
    localparam int IDX_W = $clog2(BEATS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

    seq_state_e state_q, state_d;

    logic              hit;
    logic [NBANKS-1:0] sel_dec;
    logic [RA_W-1:0]   ra_dec;

    logic [NBANKS-1:0] sel_q;
    logic [RA_W-1:0]   ra_q;
    logic              wr_q, burst_q, narrow_q, regd_q, ben_q, err_q;
    logic [FLAT_W-1:0] flat_q;
    logic [BLAT_W-1:0] blat_q;
    logic [IDX_W-1:0]  idx_q;

    logic              idle, accept, reject, cnt_zero, beat_end, last_beat;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              lc_wr, lc_narrow, lc_regd, lc_ben;
    logic [FLAT_W-1:0] lc_flat;
    logic [BLAT_W-1:0] lc_blat;
    logic [CNT_W-1:0]  first_len, beat_len;

    rom_bank_decode #(
        .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .NBANKS(NBANKS), .RA_W(RA_W)
    ) u_dec (
        .addr_i(addr_i), .width_i(width_i),
        .hit_o(hit), .sel_o(sel_dec), .rom_addr_o(ra_dec)
    );

    // In idle the live inputs set the first beat; afterwards the captured copy rules.
    assign idle      = (state_q == S_IDLE);
    assign lc_wr     = idle ? wr_i         : wr_q;
    assign lc_narrow = idle ? width_i[1]   : narrow_q;
    assign lc_regd   = idle ? regd_i       : regd_q;
    assign lc_ben    = idle ? burst_en_i   : ben_q;
    assign lc_flat   = idle ? first_lat_i  : flat_q;
    assign lc_blat   = idle ? beat_lat_i   : blat_q;

    rom_latency_calc #(
        .FLAT_W(FLAT_W), .BLAT_W(BLAT_W), .CNT_W(CNT_W)
    ) u_lat (
        .wr_i(lc_wr), .narrow_i(lc_narrow), .regd_i(lc_regd),
        .burst_en_i(lc_ben), .flat_i(lc_flat), .blat_i(lc_blat),
        .first_len_o(first_len), .beat_len_o(beat_len)
    );

    assign accept    = idle && req_i && hit;
    assign reject    = idle && req_i && !hit;
    assign beat_end  = !idle && cnt_zero;
    assign last_beat = (idx_q == LAST_IDX);

    // Counter holds (length - 1) so the zero cycle is the Nth period.
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        if (accept) begin
            cnt_load = 1'b1;
            cnt_val  = first_len - 1'b1;
        end else if (state_d == S_BURST && beat_end) begin
            cnt_load = 1'b1;
            cnt_val  = beat_len - 1'b1;
        end
    end

    rom_wait_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load_i(cnt_load), .load_val_i(cnt_val),
        .run_i(!idle), .zero_o(cnt_zero)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) state_d = S_FIRST;                 // T_ACCEPT
            end
            S_FIRST: begin
                if (cnt_zero) begin
                    state_d = burst_q ? S_BURST : S_IDLE;      // T_TOBURST / T_DONE1
                end
            end
            S_BURST: begin
                if (cnt_zero && last_beat) state_d = S_IDLE;   // T_DONEB, else T_NEXT
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture of request attributes and beat progress
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            ra_q     <= '0;
            wr_q     <= 1'b0;
            burst_q  <= 1'b0;
            narrow_q <= 1'b0;
            regd_q   <= 1'b0;
            ben_q    <= 1'b0;
            flat_q   <= '0;
            blat_q   <= '0;
            idx_q    <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= reject;
            if (accept) begin
                sel_q    <= sel_dec;
                ra_q     <= ra_dec;
                wr_q     <= wr_i;
                burst_q  <= burst_i && !wr_i;
                narrow_q <= width_i[1];
                regd_q   <= regd_i;
                ben_q    <= burst_en_i;
                flat_q   <= first_lat_i;
                blat_q   <= beat_lat_i;
                idx_q    <= '0;
            end else if (beat_end && state_d == S_BURST) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        bank_sel_o   = '0;
        rom_addr_o   = '0;
        oe_o         = 1'b0;
        we_o         = 1'b0;
        beat_valid_o = 1'b0;
        busy_o       = 1'b0;
        err_o        = err_q;
        unique case (state_q)
            S_IDLE: ;
            S_FIRST, S_BURST: begin
                busy_o       = 1'b1;
                bank_sel_o   = sel_q;
                rom_addr_o   = {ra_q[RA_W-1:IDX_W], ra_q[IDX_W-1:0] + idx_q};
                oe_o         = !wr_q;
                we_o         = wr_q;
                beat_valid_o = cnt_zero;
            end
            default: ;
        endcase
    end

    // R1: selects are exclusive and confined to busy cycles
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel_o) && (busy_o || bank_sel_o == '0));

    // R2: an error pulse never coincides with a device cycle
    p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && bank_sel_o == '0));

    // R2: the error pulse lasts one cycle unless a new reject follows
    p_err_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !reject) |=> !err_o);

    // R6: the two enables are never driven together
    p_enables_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(oe_o && we_o));

    // R7: select held throughout a multi-cycle access
    p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(bank_sel_o));

    // R9: captured latency fields do not move during an access
    p_lat_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(flat_q) && $stable(blat_q)));

    // R10: busy can only drop after a completed beat
    p_busy_until_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !beat_valid_o) |=> busy_o);
endmodule

// File: tb/rom_access_seq_test.sv
`timescale 1ns/1ps
module rom_access_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic        wr_i = 1'b0, burst_i = 1'b0, regd_i = 1'b0, burst_en_i = 1'b0;
    logic [1:0]  width_i = 2'b00;
    logic [4:0]  first_lat_i = '0;
    logic [3:0]  beat_lat_i = '0;
    logic [1:0]  bank_sel_o;
    logic [20:0] rom_addr_o;
    logic        oe_o, we_o, beat_valid_o, busy_o, err_o;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    // captured results of the latest access
    int nb, busy_last, err_k, oe_n, we_n;
    int bt [4];
    logic [20:0] ba [4];
    logic [1:0]  sel0;
    bit cs_bad;

    always #2 clk = ~clk;

    rom_access_seq uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .wr_i(wr_i),
        .burst_i(burst_i), .width_i(width_i), .regd_i(regd_i),
        .burst_en_i(burst_en_i), .first_lat_i(first_lat_i), .beat_lat_i(beat_lat_i),
        .bank_sel_o(bank_sel_o), .rom_addr_o(rom_addr_o), .oe_o(oe_o), .we_o(we_o),
        .beat_valid_o(beat_valid_o), .busy_o(busy_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_access(input logic [31:0] a, input logic wr, input logic [1:0] w,
                              input logic rg, input logic be, input logic bq,
                              input logic [4:0] fl, input logic [3:0] bl, input int chg_at);
        int prev;
        @(negedge clk);
        addr_i = a; wr_i = wr; width_i = w; regd_i = rg; burst_en_i = be;
        burst_i = bq; first_lat_i = fl; beat_lat_i = bl; req_i = 1'b1;
        @(posedge clk);
        nb = 0; busy_last = 0; err_k = 0; oe_n = 0; we_n = 0; sel0 = '0; cs_bad = 0; prev = 0;
        for (int i = 0; i < 4; i++) begin bt[i] = 0; ba[i] = '0; end
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            if (k == 1) req_i = 1'b0;
            if (chg_at != 0 && k == chg_at) begin
                req_i = 1'b1; addr_i = 32'hFF00_0040; first_lat_i = 5'd0;
                beat_lat_i = 4'd0; burst_en_i = ~burst_en_i; width_i = 2'b10;
                regd_i = ~regd_i;
            end
            if (chg_at != 0 && k == chg_at + 2) req_i = 1'b0;
            if (err_o && err_k == 0) err_k = k;
            if (busy_o) begin
                busy_last = k;
                if (sel0 == '0) sel0 = bank_sel_o;
                else if (bank_sel_o != sel0) cs_bad = 1;
                if (oe_o) oe_n++;
                if (we_o) we_n++;
            end
            if (beat_valid_o && nb < 4) begin
                bt[nb] = k - prev; ba[nb] = rom_addr_o; prev = k; nb++;
            end
            if (!busy_o) break;
        end
    endtask

    task automatic t_reset;
        check(busy_o == 0 && bank_sel_o == 0, "R10 reset busy/sel", {busy_o, bank_sel_o}, 0);
        check(!oe_o && !we_o && !beat_valid_o && !err_o, "R1 reset outputs",
              {oe_o, we_o, beat_valid_o, err_o}, 0);
    endtask

    task automatic t_wide64;
        logic [31:0] a = 32'hFFC0_1238;
        run_access(a, 0, 2'b00, 0, 0, 0, 5'd4, 4'd0, 0);
        check(nb == 1 && bt[0] == 7, "R4 64-bit read F+3", bt[0], 7);
        check(sel0 == 2'b01 && !cs_bad, "R1 bank0 select", sel0, 1);
        check(ba[0] == {1'b0, a[22:3]}, "R3 64-bit address", ba[0], {1'b0, a[22:3]});
        check(busy_last == 7 && oe_n == 7 && we_n == 0, "R10 busy span", busy_last, 7);
    endtask

    task automatic t_wide32_regd;
        logic [31:0] a = 32'hFF12_3454;
        run_access(a, 0, 2'b01, 1, 0, 0, 5'd0, 4'd0, 0);
        check(nb == 1 && bt[0] == 4, "R4 32-bit registered read", bt[0], 4);
        check(sel0 == 2'b10, "R1 bank1 select", sel0, 2);
        check(ba[0] == a[22:2], "R3 32-bit address", ba[0], a[22:2]);
    endtask

    task automatic t_byte;
        logic [31:0] a = 32'hFF9A_BCDE;
        run_access(a, 0, 2'b10, 0, 0, 0, 5'd5, 4'd0, 0);
        check(bt[0] == 7, "R5 8-bit read F+2", bt[0], 7);
        check(ba[0] == a[20:0], "R3 8-bit address", ba[0], a[20:0]);
        run_access(a, 0, 2'b11, 1, 0, 0, 5'd5, 4'd0, 0);
        check(bt[0] == 8, "R5 8-bit registered read", bt[0], 8);
    endtask

    task automatic t_write;
        run_access(32'hFF80_0100, 1, 2'b00, 1, 1, 1, 5'd3, 4'd1, 0);
        check(nb == 1 && bt[0] == 5, "R6 write F+2 ignores regd", bt[0], 5);
        check(we_n == 5 && oe_n == 0, "R6 write enables", we_n, 5);
        check(busy_last == 5, "R6 write is single beat", busy_last, 5);
    endtask

    task automatic t_burst_fast;
        run_access(32'hFF80_0010, 0, 2'b00, 0, 1, 1, 5'd2, 4'd1, 0);
        check(nb == 4, "R7 four beats", nb, 4);
        check(bt[0] == 5, "R8 first burst beat", bt[0], 5);
        for (int i = 1; i < 4; i++)
            check(bt[i] == 3, "R8 burst beat B+2", bt[i], 3);
        check(ba[0] == 21'd2 && ba[1] == 21'd3 && ba[2] == 21'd0 && ba[3] == 21'd1,
              "R7 address wraps mod 4", {ba[0][1:0], ba[1][1:0], ba[2][1:0], ba[3][1:0]}, 8'hB1);
        check(!cs_bad && sel0 == 2'b01 && busy_last == 14, "R7 select held", busy_last, 14);
    endtask

    task automatic t_burst_slow;
        run_access(32'hFF00_0008, 0, 2'b01, 0, 0, 1, 5'd1, 4'd9, 0);
        check(nb == 4, "R7 slow burst beats", nb, 4);
        for (int i = 0; i < 4; i++)
            check(bt[i] == 4, "R8 burst disabled uses first time", bt[i], 4);
        check(ba[3] == 21'd1 && sel0 == 2'b10, "R7 slow burst last address", ba[3], 1);
    endtask

    task automatic t_error;
        run_access(32'h1234_0000, 0, 2'b00, 0, 0, 0, 5'd3, 4'd0, 0);
        check(err_k == 1, "R2 error pulse at cycle 1", err_k, 1);
        check(busy_last == 0 && nb == 0 && sel0 == 0, "R2 no device cycle", busy_last, 0);
        @(negedge clk);
        check(!err_o, "R2 error pulse one cycle", err_o, 0);
    endtask

    task automatic t_midchange;
        run_access(32'hFFC0_0000, 0, 2'b00, 0, 0, 0, 5'd6, 4'd0, 3);
        check(nb == 1 && bt[0] == 9, "R9 fields frozen", bt[0], 9);
        check(sel0 == 2'b01 && !cs_bad, "R10 busy request ignored select", sel0, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!busy_o && bank_sel_o == 0, "R10 no second access", busy_o, 0);
        end
    endtask

    task automatic t_bounds;
        run_access(32'hFF7F_FFFF, 0, 2'b00, 0, 0, 0, 5'd0, 4'd0, 0);
        check(sel0 == 2'b10 && bt[0] == 3, "R1 bank1 upper edge", sel0, 2);
        run_access(32'hFF80_0000, 0, 2'b00, 0, 0, 0, 5'd0, 4'd0, 0);
        check(sel0 == 2'b01 && bt[0] == 3, "R1 bank0 lower edge", sel0, 1);
        run_access(32'hFEFF_FFFF, 0, 2'b00, 0, 0, 0, 5'd0, 4'd0, 0);
        check(err_k == 1 && busy_last == 0, "R2 just below bank1", err_k, 1);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_wide64();
        t_wide32_regd();
        t_byte();
        t_write();
        t_burst_fast();
        t_burst_slow();
        t_error();
        t_midchange();
        t_bounds();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule